// File: doc/BRIEF.md
# Subroutine Call and Return Unit

This block is the control-flow unit of a small processor core with a 20-bit program counter and two status flags, C and Z. Each cycle it may accept one decoded call, return or pop command. Every call forms a 32-bit return word. The word holds C in bit 31 and Z in bit 30. Bits 29..20 are zero. Bits 19..0 hold the address of the instruction after the call. The unit then sends this word to one of four places: a register-file write port, an internal hardware stack, a hub memory write port addressed through a post-incremented pointer, or one of four pointer registers.

Returns and pops take the newest word from the hardware stack. A return jumps to the address in the low 20 bits of that word. A return can also restore the flags from bits 31 and 30 when the issuing instruction asks for it. The implicit return that a condition-prefix encoding triggers never touches the flags. Some calls also load the flags from their target operand.

All results are registered. The next PC, the flag write strobes, and the register, hub and pointer writes appear in the cycle that follows the accepting clock edge, and they last for exactly that one cycle.

Top module: `call_return_unit`

## Requirements
- R1: After a synchronous reset, all write strobes (`pc_load`, `c_we`, `z_we`, `rf_we`, `hub_we`) are low, all four pointer registers read zero, and the hardware stack is empty.
- R2: Every call forms its return word as {C, Z, 10'b0, ret}. Here C and Z are the current `flag_c` and `flag_z`, and ret = `cur_pc` + 1 modulo 2^20.
- R3: Command code 1 (register call) writes the return word to register `d_addr` and jumps to `s_val[19:0]`. When `wr_c` is set it loads C from `s_val[31]`, and when `wr_z` is set it loads Z from `s_val[30]`. A flag whose enable is clear gets no write strobe.
- R4: The immediate-target calls (codes 4, 5 and 6) jump to `imm_addr` when `imm_rel` is 0. When `imm_rel` is 1 they jump to ret + `imm_addr` modulo 2^20.
- R5: Code 4 pushes the return word onto the hardware stack. Code 2 pushes the return word, copies `d_val` into the PA pointer (`pa_q`), and jumps to `s_val[19:0]`.
- R6: The hub calls (code 5 with an immediate target, and code 3 with target `d_val[19:0]`) write the return word at hub address PTRA[19:0], taken before the increment, and advance PTRA by 4 in the same cycle. Code 3 also loads C from `d_val[31]` and Z from `d_val[30]` under `wr_c` and `wr_z`.
- R7: Code 6 writes the return word into the pointer register that `ptr_sel` selects: 0 selects PA, 1 selects PB, 2 selects PTRA and 3 selects PTRB.
- R8: Code 7 (return) pops the stack and jumps to bits 19..0 of the popped word. Under `wr_c` and `wr_z` it restores C from bit 31 and Z from bit 30 of that word, and without them it raises no flag strobe. Code 9 (pop) writes the popped word to register `d_addr`, with the same flag rule and no jump.
- R9: Code 8 (condition-prefix return) pops and jumps like code 7, but raises no flag strobe even when `wr_c` or `wr_z` is set.
- R10: The hardware stack holds 8 words last-in first-out. A push onto a full stack discards the oldest word, and a pop from an empty stack yields zero.
- R11: A command issued with `cmd_valid` high produces its strobes in the next cycle only. With `cmd_valid` low, or with code 0, no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 4 | Command code (0 idle, 1..9 as in the requirements) |
| cur_pc | input | 20 | Address of the issuing instruction |
| imm_addr | input | 20 | Immediate target or offset |
| imm_rel | input | 1 | Immediate target is relative |
| ptr_sel | input | 2 | Pointer destination for code 6 |
| wr_c | input | 1 | C write enable |
| wr_z | input | 1 | Z write enable |
| d_addr | input | 9 | Destination register address |
| d_val | input | 32 | D operand value |
| s_val | input | 32 | S operand value |
| flag_c | input | 1 | Current C flag |
| flag_z | input | 1 | Current Z flag |
| pc_load | output | 1 | Load the next PC |
| pc_next | output | 20 | Next PC |
| c_we | output | 1 | C flag write strobe |
| c_next | output | 1 | New C value |
| z_we | output | 1 | Z flag write strobe |
| z_next | output | 1 | New Z value |
| rf_we | output | 1 | Register write strobe |
| rf_addr | output | 9 | Register write address |
| rf_data | output | 32 | Register write data |
| hub_we | output | 1 | Hub write strobe |
| hub_addr | output | 20 | Hub write byte address |
| hub_data | output | 32 | Hub write data |
| pa_q | output | 32 | PA pointer value |
| pb_q | output | 32 | PB pointer value |
| ptra_q | output | 32 | PTRA pointer value |
| ptrb_q | output | 32 | PTRB pointer value |

## Verification
A hub call stores to memory and advances PTRA on the same clock edge. The bench therefore checks, in a single sample, that `hub_addr` carries the value PTRA had before the increment and that `ptra_q` already shows that value plus 4. The bench also issues a pointer-destination call that loads PTRA and follows it at once with a hub call. The store must land at the freshly loaded address, and PTRA must step from there. A wrong forwarding order shows up as a stale address, or as a lost load or a lost increment.

// File: rtl/cru_pkg.sv
package cru_pkg;
  localparam int WORD_W = 32;
  localparam int PC_W   = 20;
  localparam int GAP_W  = WORD_W - PC_W - 2;

  typedef enum logic [3:0] {
    OP_IDLE      = 4'd0,
    OP_CALL_RF   = 4'd1,
    OP_CALL_STKD = 4'd2,
    OP_CALL_HUBD = 4'd3,
    OP_CALL_STK  = 4'd4,
    OP_CALL_HUB  = 4'd5,
    OP_CALL_PTR  = 4'd6,
    OP_RETURN    = 4'd7,
    OP_RET_PFX   = 4'd8,
    OP_POP_RF    = 4'd9
  } cru_op_e;

  typedef struct packed {
    logic              push;
    logic              pop;
    logic              pa_copy;
    logic              ptra_inc;
    logic              ptr_we;
    logic              rf_we;
    logic              hub_we;
    logic              pc_load;
    logic [PC_W-1:0]   target;
    logic              c_we;
    logic              c_val;
    logic              z_we;
    logic              z_val;
    logic [WORD_W-1:0] word;
  } cru_act_t;

  function automatic logic [WORD_W-1:0] pack_ret(input logic c, input logic z,
                                                 input logic [PC_W-1:0] addr);
    return {c, z, {GAP_W{1'b0}}, addr};
  endfunction
endpackage

// File: rtl/cru_retstack.sv
module cru_retstack #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [IW-1:0] ONE  = IW'(1);

  logic [W-1:0]  mem [DEPTH];
  logic [IW-1:0] wp;
  logic [CW-1:0] cnt;

  // storage without reset so it can map onto RAM; writing over the oldest
  // slot when full follows from the circular index
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      cnt <= '0;
    end else if (push) begin
      wp <= wp + ONE;
      if (cnt != FULL) cnt <= cnt + 1'b1;
    end else if (pop && cnt != '0) begin
      wp  <= wp - ONE;
      cnt <= cnt - 1'b1;
    end
  end

  assign top_data = (cnt == '0) ? '0 : mem[wp - ONE];

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && cnt < FULL) |=> (cnt == CW'($past(cnt) + 1'b1))); // R10
endmodule

// File: rtl/cru_ptrfile.sv
module cru_ptrfile #(
  parameter int W        = 32,
  parameter int PTR_STEP = 4,
  parameter int NPTR     = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [W-1:0]          wr_data,
  input  logic                  pa_load,
  input  logic [W-1:0]          pa_data,
  input  logic                  ptra_inc,
  output logic [NPTR-1:0][W-1:0] ptr_q
);
  localparam int IDX_PA   = 0;
  localparam int IDX_PTRA = 2;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                               q <= '0;
      else if (wr_en && wr_sel == 2'(g))     q <= wr_data;
      else if (g == IDX_PA && pa_load)       q <= pa_data;
      else if (g == IDX_PTRA && ptra_inc)    q <= q + W'(PTR_STEP);
    end
    assign ptr_q[g] = q;
  end
endmodule

// File: rtl/cru_decode.sv
module cru_decode
  import cru_pkg::*;
(
  input  logic              valid,
  input  logic [3:0]        op,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [PC_W-1:0]   imm_addr,
  input  logic              imm_rel,
  input  logic              wr_c,
  input  logic              wr_z,
  input  logic [WORD_W-1:0] d_val,
  input  logic [WORD_W-1:0] s_val,
  input  logic              flag_c,
  input  logic              flag_z,
  input  logic [WORD_W-1:0] pop_word,
  output cru_act_t          act
);
  logic [PC_W-1:0]   ret_addr;
  logic [PC_W-1:0]   imm_tgt;
  logic [WORD_W-1:0] ret_word;

  assign ret_addr = cur_pc + 1'b1;
  assign imm_tgt  = imm_rel ? (ret_addr + imm_addr) : imm_addr;
  assign ret_word = pack_ret(flag_c, flag_z, ret_addr);

  always_comb begin
    act = '0;
    act.word = ret_word;
    if (valid) begin
      unique case (cru_op_e'(op))
        OP_CALL_RF: begin
          act.rf_we   = 1'b1;
          act.pc_load = 1'b1;
          act.target  = s_val[PC_W-1:0];
          act.c_we    = wr_c;
          act.c_val   = s_val[WORD_W-1];
          act.z_we    = wr_z;
          act.z_val   = s_val[WORD_W-2];
        end
        OP_CALL_STKD: begin
          act.push    = 1'b1;
          act.pa_copy = 1'b1;
          act.pc_load = 1'b1;
          act.target  = s_val[PC_W-1:0];
        end
        OP_CALL_HUBD: begin
          act.hub_we   = 1'b1;
          act.ptra_inc = 1'b1;
          act.pc_load  = 1'b1;
          act.target   = d_val[PC_W-1:0];
          act.c_we     = wr_c;
          act.c_val    = d_val[WORD_W-1];
          act.z_we     = wr_z;
          act.z_val    = d_val[WORD_W-2];
        end
        OP_CALL_STK: begin
          act.push    = 1'b1;
          act.pc_load = 1'b1;
          act.target  = imm_tgt;
        end
        OP_CALL_HUB: begin
          act.hub_we   = 1'b1;
          act.ptra_inc = 1'b1;
          act.pc_load  = 1'b1;
          act.target   = imm_tgt;
        end
        OP_CALL_PTR: begin
          act.ptr_we  = 1'b1;
          act.pc_load = 1'b1;
          act.target  = imm_tgt;
        end
        OP_RETURN, OP_RET_PFX: begin
          act.pop     = 1'b1;
          act.pc_load = 1'b1;
          act.target  = pop_word[PC_W-1:0];
          act.c_we    = wr_c && (cru_op_e'(op) == OP_RETURN);
          act.c_val   = pop_word[WORD_W-1];
          act.z_we    = wr_z && (cru_op_e'(op) == OP_RETURN);
          act.z_val   = pop_word[WORD_W-2];
        end
        OP_POP_RF: begin
          act.pop   = 1'b1;
          act.rf_we = 1'b1;
          act.word  = pop_word;
          act.c_we  = wr_c;
          act.c_val = pop_word[WORD_W-1];
          act.z_we  = wr_z;
          act.z_val = pop_word[WORD_W-2];
        end
        default: act.word = ret_word;
      endcase
    end
  end
endmodule

// File: rtl/call_return_unit.sv
module call_return_unit
  import cru_pkg::*;
#(
  parameter int RF_AW       = 9,
  parameter int HUB_AW      = 20,
  parameter int STACK_DEPTH = 8,
  parameter int PTR_STEP    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [19:0]       cur_pc,
  input  logic [19:0]       imm_addr,
  input  logic              imm_rel,
  input  logic [1:0]        ptr_sel,
  input  logic              wr_c,
  input  logic              wr_z,
  input  logic [RF_AW-1:0]  d_addr,
  input  logic [31:0]       d_val,
  input  logic [31:0]       s_val,
  input  logic              flag_c,
  input  logic              flag_z,
  output logic              pc_load,
  output logic [19:0]       pc_next,
  output logic              c_we,
  output logic              c_next,
  output logic              z_we,
  output logic              z_next,
  output logic              rf_we,
  output logic [RF_AW-1:0]  rf_addr,
  output logic [31:0]       rf_data,
  output logic              hub_we,
  output logic [HUB_AW-1:0] hub_addr,
  output logic [31:0]       hub_data,
  output logic [31:0]       pa_q,
  output logic [31:0]       pb_q,
  output logic [31:0]       ptra_q,
  output logic [31:0]       ptrb_q
);
  localparam int NPTR = 4;

  cru_act_t                      act;
  logic [WORD_W-1:0]             top_word;
  logic [NPTR-1:0][WORD_W-1:0]   ptrs;

  cru_decode u_dec (
    .valid    (cmd_valid),
    .op       (cmd_op),
    .cur_pc   (cur_pc),
    .imm_addr (imm_addr),
    .imm_rel  (imm_rel),
    .wr_c     (wr_c),
    .wr_z     (wr_z),
    .d_val    (d_val),
    .s_val    (s_val),
    .flag_c   (flag_c),
    .flag_z   (flag_z),
    .pop_word (top_word),
    .act      (act)
  );

  cru_retstack #(.DEPTH(STACK_DEPTH), .W(WORD_W)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (act.push),
    .pop       (act.pop),
    .push_data (act.word),
    .top_data  (top_word)
  );

  cru_ptrfile #(.W(WORD_W), .PTR_STEP(PTR_STEP), .NPTR(NPTR)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (act.ptr_we),
    .wr_sel   (ptr_sel),
    .wr_data  (act.word),
    .pa_load  (act.pa_copy),
    .pa_data  (d_val),
    .ptra_inc (act.ptra_inc),
    .ptr_q    (ptrs)
  );

  assign pa_q   = ptrs[0];
  assign pb_q   = ptrs[1];
  assign ptra_q = ptrs[2];
  assign ptrb_q = ptrs[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_load <= 1'b0;
      c_we    <= 1'b0;
      z_we    <= 1'b0;
      rf_we   <= 1'b0;
      hub_we  <= 1'b0;
    end else begin
      pc_load <= act.pc_load;
      c_we    <= act.c_we;
      z_we    <= act.z_we;
      rf_we   <= act.rf_we;
      hub_we  <= act.hub_we;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_next  <= '0;
      c_next   <= 1'b0;
      z_next   <= 1'b0;
      rf_addr  <= '0;
      rf_data  <= '0;
      hub_addr <= '0;
      hub_data <= '0;
    end else begin
      pc_next  <= act.target;
      c_next   <= act.c_val;
      z_next   <= act.z_val;
      rf_addr  <= d_addr;
      rf_data  <= act.word;
      hub_addr <= ptrs[2][HUB_AW-1:0];
      hub_data <= act.word;
    end
  end

  AST_GAP_ZERO_HUB: assert property (@(posedge clk) disable iff (rst)
    hub_we |-> (hub_data[29:20] == 10'd0)); // R2
  AST_GAP_ZERO_RF: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_data[29:20] == 10'd0)); // R2
  AST_HUB_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    hub_we |-> (ptra_q[HUB_AW-1:0] == HUB_AW'(hub_addr + HUB_AW'(PTR_STEP)))); // R6
  AST_PREFIX_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_valid && cmd_op == 4'd8) |-> (!c_we && !z_we)); // R9
  AST_FLAG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (c_we |-> $past(wr_c)) and (z_we |-> $past(wr_z))); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(cmd_valid) |-> !(pc_load || rf_we || hub_we || c_we || z_we)); // R11
endmodule

// File: tb/call_return_unit_tb.sv
`timescale 1ns/1ps
module call_return_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [19:0] cur_pc, imm_addr;
  logic        imm_rel, wr_c, wr_z, flag_c, flag_z;
  logic [1:0]  ptr_sel;
  logic [8:0]  d_addr;
  logic [31:0] d_val, s_val;
  logic        pc_load, c_we, c_next, z_we, z_next, rf_we, hub_we;
  logic [19:0] pc_next, hub_addr;
  logic [8:0]  rf_addr;
  logic [31:0] rf_data, hub_data, pa_q, pb_q, ptra_q, ptrb_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  call_return_unit u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cur_pc(cur_pc), .imm_addr(imm_addr), .imm_rel(imm_rel), .ptr_sel(ptr_sel),
    .wr_c(wr_c), .wr_z(wr_z), .d_addr(d_addr), .d_val(d_val), .s_val(s_val),
    .flag_c(flag_c), .flag_z(flag_z), .pc_load(pc_load), .pc_next(pc_next),
    .c_we(c_we), .c_next(c_next), .z_we(z_we), .z_next(z_next),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
    .hub_we(hub_we), .hub_addr(hub_addr), .hub_data(hub_data),
    .pa_q(pa_q), .pb_q(pb_q), .ptra_q(ptra_q), .ptrb_q(ptrb_q)
  );

  function automatic logic [31:0] rw(input logic c, input logic z, input logic [19:0] pc);
    return {c, z, 10'd0, pc + 20'd1};
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic setup(input logic [3:0] op, input logic [19:0] pc, input logic c,
                       input logic z, input logic ec, input logic ez);
    cmd_op = op; cur_pc = pc; flag_c = c; flag_z = z; wr_c = ec; wr_z = ez;
    imm_rel = 1'b0; imm_addr = '0; ptr_sel = '0; d_addr = '0; d_val = '0; s_val = '0;
  endtask

  // called right after a falling edge; returns after the next falling edge
  task automatic fire();
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 strobes", {27'd0, pc_load, c_we, z_we, rf_we, hub_we}, 32'd0);
    chk("R1 pa", pa_q, 0); chk("R1 pb", pb_q, 0);
    chk("R1 ptra", ptra_q, 0); chk("R1 ptrb", ptrb_q, 0);
  endtask

  task automatic t_reg_call();
    setup(4'd1, 20'h00100, 1'b1, 1'b0, 1'b1, 1'b1);
    d_addr = 9'h1A5; s_val = 32'h8000_0345;
    fire();
    chk("R3 rf_we", rf_we, 1); chk("R3 rf_addr", rf_addr, 9'h1A5);
    chk("R2 rf_data", rf_data, 32'h8000_0101);
    chk("R3 pc", pc_next, 20'h00345); chk("R3 pc_load", pc_load, 1);
    chk("R3 flags", {c_we, c_next, z_we, z_next}, 4'b1110);
    setup(4'd1, 20'h00200, 1'b0, 1'b1, 1'b0, 1'b0);
    s_val = 32'hC000_0010;
    fire();
    chk("R3 no flag strobe", {c_we, z_we}, 2'b00);
    chk("R2 rf_data z", rf_data, 32'h4000_0201);
  endtask

  task automatic t_stack_call_ret();
    setup(4'd4, 20'h00200, 1'b0, 1'b1, 1'b0, 1'b0);
    imm_addr = 20'h01234;
    fire();
    chk("R4 abs target", pc_next, 20'h01234);
    setup(4'd4, 20'hFFFFE, 1'b1, 1'b1, 1'b0, 1'b0);
    imm_addr = 20'h00005; imm_rel = 1'b1;
    fire();
    chk("R4 rel wrap target", pc_next, 20'h00004);
    setup(4'd7, 20'h00050, 1'b0, 1'b0, 1'b1, 1'b1);
    fire();
    chk("R8 ret pc", pc_next, 20'hFFFFF); chk("R8 ret load", pc_load, 1);
    chk("R8 restore", {c_we, c_next, z_we, z_next}, 4'b1111);
    setup(4'd7, 20'h00060, 1'b1, 1'b1, 1'b0, 1'b0);
    fire();
    chk("R5 R8 ret pc 2", pc_next, 20'h00201);
    chk("R8 no restore", {c_we, z_we}, 2'b00);
  endtask

  task automatic t_stack_pa();
    setup(4'd2, 20'h00010, 1'b1, 1'b0, 1'b0, 1'b0);
    d_val = 32'hDEAD_BEEF; s_val = 32'h0000_0077;
    fire();
    chk("R5 pa copy", pa_q, 32'hDEAD_BEEF); chk("R5 target", pc_next, 20'h00077);
    setup(4'd9, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    d_addr = 9'h003;
    fire();
    chk("R5 pushed word", rf_data, rw(1'b1, 1'b0, 20'h00010));
    chk("R8 pop no jump", pc_load, 0);
    chk("R8 pop rf_addr", rf_addr, 9'h003);
  endtask

  task automatic t_hub();
    setup(4'd5, 20'h00300, 1'b0, 1'b1, 1'b0, 1'b0);
    imm_addr = 20'h00400;
    fire();
    chk("R6 hub_we", hub_we, 1); chk("R6 hub_addr", hub_addr, 20'h0);
    chk("R6 hub_data", hub_data, 32'h4000_0301); chk("R6 ptra", ptra_q, 32'd4);
    chk("R4 hub target", pc_next, 20'h00400);
    setup(4'd3, 20'h00400, 1'b0, 1'b0, 1'b1, 1'b1);
    d_val = 32'hC001_2345;
    fire();
    chk("R6 ind addr", hub_addr, 20'h4); chk("R6 ptra 8", ptra_q, 32'd8);
    chk("R6 ind target", pc_next, 20'h12345);
    chk("R6 ind flags", {c_we, c_next, z_we, z_next}, 4'b1111);
  endtask

  task automatic t_ptr_call();
    for (int i = 0; i < 4; i++) begin
      setup(4'd6, 20'h00500 + 20'(i * 16), 1'b1, 1'b0, 1'b0, 1'b0);
      ptr_sel = 2'(i); imm_addr = 20'h00700;
      fire();
      chk("R7 target", pc_next, 20'h00700);
    end
    chk("R7 pa", pa_q, rw(1'b1, 1'b0, 20'h00500));
    chk("R7 pb", pb_q, rw(1'b1, 1'b0, 20'h00510));
    chk("R7 ptra", ptra_q, rw(1'b1, 1'b0, 20'h00520));
    chk("R7 ptrb", ptrb_q, rw(1'b1, 1'b0, 20'h00530));
    setup(4'd6, 20'h00540, 1'b1, 1'b0, 1'b0, 1'b0);
    ptr_sel = 2'd2;
    fire();
    setup(4'd5, 20'h00600, 1'b0, 1'b0, 1'b0, 1'b0);
    fire();
    chk("R6 R7 back-to-back addr", hub_addr, 20'h00541);
    chk("R6 R7 back-to-back ptra", ptra_q, 32'h8000_0545);
    chk("R6 data", hub_data, 32'h0000_0601);
  endtask

  task automatic t_prefix_ret();
    setup(4'd4, 20'h00800, 1'b1, 1'b1, 1'b0, 1'b0);
    imm_addr = 20'h00900;
    fire();
    setup(4'd8, 20'h00900, 1'b0, 1'b0, 1'b1, 1'b1);
    fire();
    chk("R9 pc", pc_next, 20'h00801);
    chk("R9 no flags", {c_we, z_we}, 2'b00);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 10; i++) begin
      setup(4'd4, 20'(i * 16), 1'b0, 1'b0, 1'b0, 1'b0);
      fire();
    end
    for (int i = 9; i >= 2; i--) begin
      setup(4'd9, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      fire();
      chk("R10 lifo", rf_data, rw(1'b0, 1'b0, 20'(i * 16)));
    end
    setup(4'd9, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    fire();
    chk("R10 empty pop", rf_data, 32'd0);
    setup(4'd7, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    fire();
    chk("R10 empty ret pc", pc_next, 20'd0);
  endtask

  task automatic t_idle();
    setup(4'd1, 20'h00123, 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    chk("R11 invalid quiet", {27'd0, pc_load, c_we, z_we, rf_we, hub_we}, 32'd0);
    setup(4'd0, 20'h00123, 1'b0, 1'b0, 1'b1, 1'b1);
    fire();
    chk("R11 idle code quiet", {27'd0, pc_load, c_we, z_we, rf_we, hub_we}, 32'd0);
    setup(4'd5, 20'h00123, 1'b0, 1'b0, 1'b0, 1'b0);
    fire();
    chk("R11 strobe now", hub_we, 1);
    @(negedge clk);
    chk("R11 strobe one cycle", hub_we, 0);
  endtask

  initial begin
    rst = 1'b1; cmd_valid = 1'b0;
    setup(4'd0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reg_call();
    t_stack_call_ret();
    t_stack_pa();
    t_hub();
    t_ptr_call();
    t_prefix_ret();
    t_overflow();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule